// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a small serial EEPROM and decides, one request at a time, whether a status-register update or an array byte write may go ahead. A command decoder in front of it hands over decoded requests: a write-enable command, a status-write request with its data byte, and an array-write request with its byte address. The block answers each request with a one-cycle permit pulse. The status byte is always available for a read command.

Writes are guarded in four ways. An internal write-enable latch must be set before any write, and it is cleared by every write request, whether that request is honoured or refused. A protect-enable bit, combined with a low level on the hardware protect pin, freezes the status register until the pin is driven high. Two lock bits fence off the upper quarter, the upper half or the whole of the array. No write is allowed while a nonvolatile write is in progress.

Top module: `sdp_guard`

## Requirements
- R1: After reset the status byte reads 0x00 (with `nv_busy` low), the write-enable latch is clear, the lock code is 00, the protect-enable bit is 0, and both permit outputs are low.
- R2: A `wren_cmd` cycle with no write request sets the write-enable latch, and status bit 1 reads 1 from the next cycle on.
- R3: A permitted status write takes status bit 7 (protect enable) and bits 3:2 (lock code) from the data byte, and raises `sr_wr_ok` for exactly the one cycle after the request.
- R4: When `wp_pin` is high, a status write with the latch set is permitted even if the protect-enable bit is 1.
- R5: When the protect-enable bit is 1 and `wp_pin` is low, a status write is refused: `sr_wr_ok` stays low and bits 7 and 3:2 keep their values.
- R6: When the protect-enable bit is 0, a status write is permitted with `wp_pin` low, and it may set the protect-enable bit.
- R7: Data bits 6:4, 1 and 0 of a status write are not stored. Status bits 6:4 always read 0.
- R8: Status bit 0 follows `nv_busy` in the same cycle. While `nv_busy` is high, status and array writes are refused.
- R9: The lock code in bits 3:2 refuses array writes as follows: 00 refuses none, 01 refuses the top quarter of the addresses, 10 refuses the top half, and 11 refuses all. A refused array write leaves `arr_wr_ok` low.
- R10: A write without the latch set is refused. Every status or array write request clears the latch, whether it is honoured or refused.
- R11: When requests arrive in the same cycle, a status request takes priority over an array request, and the array request is dropped. `wren_cmd` is ignored in any cycle that carries a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_pin | input | 1 | Hardware protect pin; low protects when the protect-enable bit is 1 |
| nv_busy | input | 1 | Nonvolatile write in progress |
| wren_cmd | input | 1 | Decoded write-enable command, one cycle |
| sr_wr_req | input | 1 | Decoded status-write request, one cycle |
| sr_wr_data | input | 8 | Data byte for the status write |
| arr_wr_req | input | 1 | Decoded array-write request, one cycle |
| arr_wr_addr | input | ADDR_W | Byte address of the array write |
| status | output | 8 | Status byte for reads |
| sr_wr_ok | output | 1 | Status write permitted, one-cycle pulse |
| arr_wr_ok | output | 1 | Array write permitted, one-cycle pulse |

## Verification
Status bit 0 is combinational from `nv_busy`, so it is checked in the same cycle that the busy input is driven. Every other result comes through one register. A request applied before clock edge N produces its permit pulse, its new latch state and its new status bits in the cycle that follows edge N. The bench drives inputs on the falling edge, removes them at the next falling edge, and samples at that same falling edge, which falls inside the cycle after the edge that took the request. Refusals are observed as a low permit at that sample point, together with a status byte that kept its old bits.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    // status byte bit positions
    localparam int SR_BUSY = 0;
    localparam int SR_WEL  = 1;
    localparam int SR_LK_L = 2;
    localparam int SR_LK_H = 3;
    localparam int SR_PEN  = 7;

    // bits a status write may change
    localparam logic [7:0] SR_WMASK = 8'h8C;

    typedef enum logic [1:0] {
        LOCK_NONE  = 2'b00,
        LOCK_QUART = 2'b01,
        LOCK_HALF  = 2'b10,
        LOCK_ALL   = 2'b11
    } lock_code_e;

    typedef struct packed {
        logic [7:0] img;     // stored writable bits (mask applied)
        logic       wel;
        logic       sr_ok;
        logic       arr_ok;
    } guard_state_t;

endpackage

// File: rtl/sdp_lock_decode.sv
module sdp_lock_decode #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        lock_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import sdp_pkg::*;

    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (lock_code_e'(lock_code))
            LOCK_NONE:  locked = 1'b0;
            LOCK_QUART: locked = &addr[TOP -: 2];
            LOCK_HALF:  locked = addr[TOP];
            default:    locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/sdp_sr_permit.sv
module sdp_sr_permit (
    input  logic wel,
    input  logic busy,
    input  logic pen,
    input  logic wp_pin,
    output logic sr_allow
);
    logic hw_frozen;

    always_comb begin
        hw_frozen = pen & ~wp_pin;
        sr_allow  = wel & ~busy & ~hw_frozen;
    end

endmodule

// File: rtl/sdp_guard.sv
module sdp_guard #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              nv_busy,
    input  logic              wren_cmd,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    output logic [7:0]        status,
    output logic              sr_wr_ok,
    output logic              arr_wr_ok
);
    import sdp_pkg::*;

    guard_state_t st_d, st_q;
    logic         sr_allow;
    logic         addr_locked;

    sdp_sr_permit u_permit (
        .wel      (st_q.wel),
        .busy     (nv_busy),
        .pen      (st_q.img[SR_PEN]),
        .wp_pin   (wp_pin),
        .sr_allow (sr_allow)
    );

    sdp_lock_decode #(.ADDR_W(ADDR_W)) u_lock (
        .lock_code (st_q.img[SR_LK_H:SR_LK_L]),
        .addr      (arr_wr_addr),
        .locked    (addr_locked)
    );

    always_comb begin
        st_d        = st_q;
        st_d.sr_ok  = 1'b0;
        st_d.arr_ok = 1'b0;
        if (sr_wr_req) begin
            st_d.wel = 1'b0;
            if (sr_allow) begin
                st_d.img   = sr_wr_data & SR_WMASK;
                st_d.sr_ok = 1'b1;
            end
        end else if (arr_wr_req) begin
            st_d.wel    = 1'b0;
            st_d.arr_ok = st_q.wel & ~nv_busy & ~addr_locked;
        end else if (wren_cmd) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status          = st_q.img;
        status[SR_WEL]  = st_q.wel;
        status[SR_BUSY] = nv_busy;
    end

    assign sr_wr_ok  = st_q.sr_ok;
    assign arr_wr_ok = st_q.arr_ok;

    // R5
    frozen_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req && st_q.img[SR_PEN] && !wp_pin) |=> !sr_wr_ok);

    // R3
    img_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_ok |-> $stable(st_q.img));

    // R10
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req || arr_wr_req) |=> !status[SR_WEL]);

    // R10
    permit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_ok || arr_wr_ok) |-> $past(st_q.wel));

    // R9
    all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req && st_q.img[SR_LK_H:SR_LK_L] == 2'b11) |=> !arr_wr_ok);

    // R11
    one_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_wr_ok, arr_wr_ok}));

    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> !(sr_wr_ok || arr_wr_ok));

endmodule

// File: tb/sdp_guard_tb.sv
module sdp_guard_tb;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_pin = 1'b0;
    logic          nv_busy = 1'b0;
    logic          wren_cmd = 1'b0;
    logic          sr_wr_req = 1'b0;
    logic [7:0]    sr_wr_data = '0;
    logic          arr_wr_req = 1'b0;
    logic [AW-1:0] arr_wr_addr = '0;
    logic [7:0]    status;
    logic          sr_wr_ok;
    logic          arr_wr_ok;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sdp_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .nv_busy(nv_busy),
        .wren_cmd(wren_cmd), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
        .arr_wr_req(arr_wr_req), .arr_wr_addr(arr_wr_addr),
        .status(status), .sr_wr_ok(sr_wr_ok), .arr_wr_ok(arr_wr_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wren();
        @(negedge clk); wren_cmd = 1'b1;
        @(negedge clk); wren_cmd = 1'b0;
    endtask

    task automatic do_sr(input logic [7:0] d, output logic ok);
        @(negedge clk); sr_wr_req = 1'b1; sr_wr_data = d;
        @(negedge clk); sr_wr_req = 1'b0; ok = sr_wr_ok;
    endtask

    task automatic do_arr(input logic [AW-1:0] a, output logic ok);
        @(negedge clk); arr_wr_req = 1'b1; arr_wr_addr = a;
        @(negedge clk); arr_wr_req = 1'b0; ok = arr_wr_ok;
    endtask

    task automatic set_lock(input logic [1:0] code);
        logic ok;
        wp_pin = 1'b1;
        do_wren();
        do_sr({6'b0, code} << 2, ok);
        check("R9 lock setup", ok, 1'b1);
        check("R9 lock readback", status, {4'b0, code, 2'b00});
    endtask

    task automatic t_reset();
        check("R1 status", status, 8'h00);
        check("R1 sr_wr_ok", sr_wr_ok, 1'b0);
        check("R1 arr_wr_ok", arr_wr_ok, 1'b0);
    endtask

    task automatic t_wel();
        logic ok;
        do_sr(8'h80, ok);
        check("R10 no latch sr", ok, 1'b0);
        check("R10 no latch status", status, 8'h00);
        do_wren();
        check("R2 latch set", status, 8'h02);
    endtask

    task automatic t_sr_low_pin();
        logic ok;
        wp_pin = 1'b0;
        do_sr(8'hFF, ok);
        check("R6 write with pin low", ok, 1'b1);
        check("R3 R7 status after write", status, 8'h8C);
        @(negedge clk);
        check("R3 pulse one cycle", sr_wr_ok, 1'b0);
    endtask

    task automatic t_frozen();
        logic ok;
        do_wren();
        do_sr(8'h00, ok);
        check("R5 refused", ok, 1'b0);
        check("R5 R10 status kept, latch cleared", status, 8'h8C);
    endtask

    task automatic t_pin_high();
        logic ok;
        wp_pin = 1'b1;
        do_wren();
        do_sr(8'h84, ok);
        check("R4 pin high allows", ok, 1'b1);
        check("R4 status", status, 8'h84);
        wp_pin = 1'b0;
        do_wren();
        do_sr(8'h00, ok);
        check("R5 refrozen", ok, 1'b0);
        wp_pin = 1'b1;
        do_wren();
        do_sr(8'h00, ok);
        check("R4 unlock", ok, 1'b1);
        check("R4 status cleared", status, 8'h00);
    endtask

    task automatic t_array();
        logic [AW-1:0] addrs [6] = '{11'h000, 11'h3FF, 11'h400, 11'h5FF, 11'h600, 11'h7FF};
        logic ok;
        for (int c = 0; c < 4; c++) begin
            set_lock(c[1:0]);
            for (int i = 0; i < 6; i++) begin
                logic exp_ok;
                case (c)
                    0: exp_ok = 1'b1;
                    1: exp_ok = (addrs[i] < 11'h600);
                    2: exp_ok = (addrs[i] < 11'h400);
                    default: exp_ok = 1'b0;
                endcase
                do_wren();
                do_arr(addrs[i], ok);
                check("R9 array permit", ok, exp_ok);
                check("R10 latch cleared after array", status[1], 1'b0);
            end
        end
        set_lock(2'b00);
        do_arr(11'h010, ok);
        check("R10 array without latch", ok, 1'b0);
    endtask

    task automatic t_busy();
        logic ok;
        @(negedge clk); nv_busy = 1'b1;
        #1 check("R8 busy bit", status[0], 1'b1);
        do_wren();
        do_sr(8'h0C, ok);
        check("R8 sr refused busy", ok, 1'b0);
        check("R8 status kept", status, 8'h01);
        do_wren();
        do_arr(11'h001, ok);
        check("R8 array refused busy", ok, 1'b0);
        @(negedge clk); nv_busy = 1'b0;
        #1 check("R8 busy cleared", status[0], 1'b0);
    endtask

    task automatic t_prio();
        do_wren();
        @(negedge clk);
        sr_wr_req = 1'b1; sr_wr_data = 8'h08; arr_wr_req = 1'b1; arr_wr_addr = 11'h001;
        @(negedge clk);
        sr_wr_req = 1'b0; arr_wr_req = 1'b0;
        check("R11 status wins", sr_wr_ok, 1'b1);
        check("R11 array dropped", arr_wr_ok, 1'b0);
        check("R11 status value", status, 8'h08);
        @(negedge clk);
        wren_cmd = 1'b1; sr_wr_req = 1'b1; sr_wr_data = 8'h00;
        @(negedge clk);
        wren_cmd = 1'b0; sr_wr_req = 1'b0;
        check("R11 wren ignored with request", status, 8'h08);
        check("R11 no permit", sr_wr_ok, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wel();
        t_sr_low_pin();
        t_frozen();
        t_pin_high();
        t_array();
        t_busy();
        t_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule